// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Redirection Table

This block is the bus-facing front end of an interrupt router. Software does not address the router's registers directly. It first writes an index into a select register, then reads or writes a 32-bit data window, and the block routes that access to the register the index names. Behind the window are a router ID register, a read-only version register, an arbitration register that mirrors the ID, and a table of redirection entries. Each entry is 64 bits wide and is reached as two 32-bit halves. A separate end-of-interrupt register at its own offset passes a vector to the downstream EOI logic. That register is honoured only when the block is built as version 0x20.

A write to an entry never changes its two read-only status bits, delivery status and remote-IRR. The pin engine sets those bits through a status port. A write that leaves an entry edge-triggered clears its remote-IRR. After each entry write the block pulses a strobe with the entry number, so the pin engine can service pending requests again. The pin engine also reads any entry through a combinational lookup port.

The bus is a single-beat request/response port. A request is taken in the cycle `req_valid` is high. The response follows one cycle later, with read data for reads and zero for writes.

Top module: `irq_regwin`

## Requirements
- R1: After reset the select register and the ID read as zero, every entry reads as 0x0000_0000_0001_0000 (only the mask bit 16 set), and `rsp_valid`, `ent_wr_stb` and `eoi_stb` are low.
- R2: A write to offset 0x00 stores `req_wdata[7:0]` into the select register whatever `req_size` is. A read of offset 0x00 returns the select value zero-extended, whatever the size.
- R3: `req_size` gives the byte count (1, 2 or 4). A window access (offset 0x10) whose size is not 4 reads as zero, and as a write it changes no register and raises no strobe.
- R4: Window index 0x00 (ID) and index 0x02 (arbitration) both read as the ID placed at bits [27:24]. A 4-byte write to index 0x00 stores only `req_wdata[27:24]`.
- R5: Window index 0x01 reads as VERSION in bits [7:0] OR'd with (PINS-1) in bits [23:16], which is 0x0017_0020 by default. Writes to indices 0x01 and 0x02 have no effect.
- R6: Entry n is at index 0x10+2n for bits [31:0] and at index 0x11+2n for bits [63:32]. Indices 0x03 to 0x0F and indices from 0x10+2·PINS upward read as zero, and writes to them are ignored.
- R7: An entry write keeps the previous values of bit 12 (delivery status) and bit 14 (remote-IRR), whatever data is written. All other bits of the addressed half take the new data.
- R8: After an entry write, if bit 15 (trigger, 0 = edge) is 0, remote-IRR reads as 0. If bit 15 is 1, remote-IRR keeps its value.
- R9: One cycle after an accepted entry write, `ent_wr_stb` is high for one cycle and `ent_wr_index` holds the entry number. Writes to any other register leave the strobe low. `rsp_valid` follows `req_valid` by one cycle.
- R10: A 4-byte write to offset 0x40 raises `eoi_stb` one cycle later, with `eoi_vector` equal to `req_wdata[7:0]`, only when VERSION is 0x20. Other sizes, and builds with VERSION 0x11, raise no strobe. VERSION may only be 0x11 or 0x20.
- R11: When `st_valid` is high, entry `st_index` has its remote-IRR set to `st_remote_irr` and its delivery status set to `st_deliv` at the next clock edge.
- R12: `eng_entry` returns the full 64-bit entry selected by `eng_index` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Register offset (0x00 select, 0x10 window, 0x40 EOI) |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| st_valid | input | 1 | Status update from the pin engine |
| st_index | input | IDX_W | Entry that the status update targets |
| st_remote_irr | input | 1 | New remote-IRR value |
| st_deliv | input | 1 | New delivery-status value |
| eng_index | input | IDX_W | Entry lookup index |
| eng_entry | output | 64 | Entry lookup data |
| ent_wr_stb | output | 1 | An entry was just written |
| ent_wr_index | output | IDX_W | Number of the written entry |
| eoi_stb | output | 1 | End-of-interrupt request |
| eoi_vector | output | 8 | Vector that comes with the EOI |

## Verification
The hardest cases to reach are those where the read-only bits already hold ones when software writes an entry. The bus cannot set them, so the bench first drives the pin engine's status port to set remote-IRR and delivery status on chosen entries. It then writes those entries through the window. It writes one as level, with the read-only bits zero in the data, and rewrites another as edge, to show both that the bits are preserved and that the edge rule clears them. The version-gated EOI is covered by a second instance built as version 0x11, which receives the same request stream.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam int ENT_W  = 64;
  localparam int B_DLV  = 12;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;

  localparam logic [ENT_W-1:0] RO_MASK   = (64'd1 << B_DLV) | (64'd1 << B_RIRR);
  localparam logic [ENT_W-1:0] ENT_RESET = 64'd1 << B_MASK;

  typedef enum logic [1:0] {K_SELECT, K_WINDOW, K_EOI, K_NONE} kind_e;

  // overwrite the two status bits of an entry
  function automatic logic [ENT_W-1:0] apply_status(logic [ENT_W-1:0] e,
                                                    logic rirr, logic dlv);
    logic [ENT_W-1:0] r;
    r         = e;
    r[B_RIRR] = rirr;
    r[B_DLV]  = dlv;
    return r;
  endfunction

  // replace one 32-bit half, restore protected bits, apply edge rule
  function automatic logic [ENT_W-1:0] merge_half(logic [ENT_W-1:0] cur,
                                                  logic hi, logic [31:0] wd);
    logic [ENT_W-1:0] r;
    r = hi ? {wd, cur[31:0]} : {cur[63:32], wd};
    r = (r & ~RO_MASK) | (cur & RO_MASK);
    if (!r[B_TRIG]) r[B_RIRR] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] version_word(logic [7:0] ver, int pins);
    logic [7:0] top_ent;
    top_ent = 8'(pins - 1);
    return {8'h00, top_ent, 8'h00, ver};
  endfunction

  function automatic logic [31:0] id_word(logic [7:0] id, int lsb);
    return 32'(id) << lsb;
  endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int         PINS     = 24,
  parameter logic [7:0] SEL_OFS  = 8'h00,
  parameter logic [7:0] WIN_OFS  = 8'h10,
  parameter logic [7:0] EOI_OFS  = 8'h40,
  parameter logic [7:0] ENT_BASE = 8'h10,
  localparam int        IDX_W    = $clog2(PINS)
) (
  input  logic [7:0]       offset,
  input  logic [7:0]       sel,
  output kind_e            kind,
  output logic             win_is_id,
  output logic             win_is_ver,
  output logic             win_is_arb,
  output logic             win_is_entry,
  output logic             win_hi,
  output logic [IDX_W-1:0] win_idx
);

  logic [7:0] rel;

  always_comb begin
    if (offset == SEL_OFS)      kind = K_SELECT;
    else if (offset == WIN_OFS) kind = K_WINDOW;
    else if (offset == EOI_OFS) kind = K_EOI;
    else                        kind = K_NONE;
  end

  assign rel          = sel - ENT_BASE;
  assign win_is_id    = (sel == 8'h00);
  assign win_is_ver   = (sel == 8'h01);
  assign win_is_arb   = (sel == 8'h02);
  assign win_is_entry = (sel >= ENT_BASE) && ({1'b0, rel[7:1]} < 8'(PINS));
  assign win_hi       = rel[0];
  assign win_idx      = rel[IDX_W:1];

endmodule

// File: rtl/irw_entry_bank.sv
module irw_entry_bank
  import irw_pkg::*;
#(
  parameter int  PINS  = 24,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic             st_en,
  input  logic [IDX_W-1:0] st_idx,
  input  logic             st_rirr,
  input  logic             st_dlv,
  output logic [ENT_W-1:0] entries [PINS]
);

  for (genvar g = 0; g < PINS; g++) begin : g_ent
    logic [ENT_W-1:0] q;
    logic [ENT_W-1:0] cur;
    logic             wr_hit;

    assign cur    = (st_en && st_idx == IDX_W'(g)) ? apply_status(q, st_rirr, st_dlv) : q;
    assign wr_hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)      q <= ENT_RESET;
      else if (wr_hit) q <= merge_half(cur, wr_hi, wr_data);
      else             q <= cur;
    end

    assign entries[g] = q;
  end

endmodule

// File: rtl/irw_readmux.sv
module irw_readmux
  import irw_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int         ID_W    = 4,
  parameter int         ID_LSB  = 24
) (
  input  kind_e            kind,
  input  logic [2:0]       size,
  input  logic [7:0]       sel,
  input  logic [ID_W-1:0]  id,
  input  logic             win_is_id,
  input  logic             win_is_ver,
  input  logic             win_is_arb,
  input  logic             win_is_entry,
  input  logic             win_hi,
  input  logic [ENT_W-1:0] win_entry,
  output logic [31:0]      rdata
);

  logic [31:0] win_word;

  always_comb begin
    if (win_is_id || win_is_arb) win_word = id_word(8'(id), ID_LSB);
    else if (win_is_ver)         win_word = version_word(VERSION, PINS);
    else if (win_is_entry)       win_word = win_hi ? win_entry[63:32] : win_entry[31:0];
    else                         win_word = 32'h0;
  end

  always_comb begin
    unique case (kind)
      K_SELECT: rdata = {24'h0, sel};
      K_WINDOW: rdata = (size == 3'd4) ? win_word : 32'h0;
      default:  rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irw_pkg::*;
#(
  parameter int         PINS     = 24,
  parameter logic [7:0] VERSION  = 8'h20,
  parameter int         ID_W     = 4,
  parameter int         ID_LSB   = 24,
  parameter logic [7:0] SEL_OFS  = 8'h00,
  parameter logic [7:0] WIN_OFS  = 8'h10,
  parameter logic [7:0] EOI_OFS  = 8'h40,
  parameter logic [7:0] ENT_BASE = 8'h10,
  localparam int        IDX_W    = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_offset,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic             st_valid,
  input  logic [IDX_W-1:0] st_index,
  input  logic             st_remote_irr,
  input  logic             st_deliv,
  input  logic [IDX_W-1:0] eng_index,
  output logic [63:0]      eng_entry,
  output logic             ent_wr_stb,
  output logic [IDX_W-1:0] ent_wr_index,
  output logic             eoi_stb,
  output logic [7:0]       eoi_vector
);

  if (!(VERSION == 8'h11 || VERSION == 8'h20)) begin : g_bad_version
    $error("irq_regwin: VERSION must be 0x11 or 0x20");
  end

  logic [7:0]       sel_q;
  logic [ID_W-1:0]  id_q;
  kind_e            kind;
  logic             win_is_id, win_is_ver, win_is_arb, win_is_entry, win_hi;
  logic [IDX_W-1:0] win_idx;
  logic [ENT_W-1:0] entries [PINS];
  logic [ENT_W-1:0] win_entry;
  logic [ENT_W-1:0] stb_entry;
  logic [31:0]      rdata;

  // named events for the checker
  logic win_wr_ok;
  logic wr_fire;
  logic st_same;
  logic eoi_fire;

  irw_decode #(
    .PINS(PINS), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS),
    .EOI_OFS(EOI_OFS), .ENT_BASE(ENT_BASE)
  ) u_dec (
    .offset(req_offset), .sel(sel_q), .kind(kind),
    .win_is_id(win_is_id), .win_is_ver(win_is_ver), .win_is_arb(win_is_arb),
    .win_is_entry(win_is_entry), .win_hi(win_hi), .win_idx(win_idx)
  );

  assign win_wr_ok = req_valid && req_write && (kind == K_WINDOW) && (req_size == 3'd4);
  assign wr_fire   = win_wr_ok && win_is_entry;
  assign st_same   = st_valid && (st_index == win_idx);
  assign eoi_fire  = req_valid && req_write && (kind == K_EOI) && (req_size == 3'd4)
                     && (VERSION == 8'h20);

  irw_entry_bank #(.PINS(PINS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_idx(win_idx), .wr_hi(win_hi), .wr_data(req_wdata),
    .st_en(st_valid), .st_idx(st_index), .st_rirr(st_remote_irr), .st_dlv(st_deliv),
    .entries(entries)
  );

  assign win_entry = win_is_entry ? entries[win_idx] : '0;
  assign stb_entry = entries[ent_wr_index];
  assign eng_entry = ({1'b0, eng_index} < (IDX_W+1)'(PINS)) ? entries[eng_index] : '0;

  irw_readmux #(
    .PINS(PINS), .VERSION(VERSION), .ID_W(ID_W), .ID_LSB(ID_LSB)
  ) u_rmux (
    .kind(kind), .size(req_size), .sel(sel_q), .id(id_q),
    .win_is_id(win_is_id), .win_is_ver(win_is_ver), .win_is_arb(win_is_arb),
    .win_is_entry(win_is_entry), .win_hi(win_hi), .win_entry(win_entry),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= 8'h00;
      id_q         <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= 32'h0;
      ent_wr_stb   <= 1'b0;
      ent_wr_index <= '0;
      eoi_stb      <= 1'b0;
      eoi_vector   <= 8'h00;
    end else begin
      if (req_valid && req_write && kind == K_SELECT) sel_q <= req_wdata[7:0];
      if (win_wr_ok && win_is_id) id_q <= req_wdata[ID_LSB +: ID_W];
      rsp_valid  <= req_valid;
      rsp_rdata  <= (req_valid && !req_write) ? rdata : 32'h0;
      ent_wr_stb <= wr_fire;
      if (wr_fire) ent_wr_index <= win_idx;
      eoi_stb    <= eoi_fire;
      if (eoi_fire) eoi_vector <= req_wdata[7:0];
    end
  end

endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk
  import irw_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter logic [7:0] WIN_OFS = 8'h10,
  parameter logic [7:0] EOI_OFS = 8'h40,
  localparam int        IDX_W   = $clog2(PINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [7:0]       req_offset,
  input logic [2:0]       req_size,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic             wr_fire,
  input logic             st_same,
  input logic [ENT_W-1:0] win_entry,
  input logic [ENT_W-1:0] stb_entry,
  input logic             ent_wr_stb,
  input logic             eoi_stb,
  input logic [7:0]       eoi_vector
);

  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r9_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ent_wr_stb);

  a_r3_short_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_offset == WIN_OFS && req_size != 3'd4) |=> !ent_wr_stb);

  a_r7_ro_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !st_same) |=>
      (stb_entry[B_DLV] == $past(win_entry[B_DLV])) &&
      (!stb_entry[B_TRIG] || stb_entry[B_RIRR] == $past(win_entry[B_RIRR])));

  a_r8_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_wr_stb && !stb_entry[B_TRIG]) |-> !stb_entry[B_RIRR]);

  a_r10_eoi_source: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb |-> (VERSION == 8'h20) &&
      $past(req_valid && req_write && req_offset == EOI_OFS && req_size == 3'd4) &&
      (eoi_vector == $past(req_wdata[7:0])));

endmodule

bind irq_regwin irq_regwin_chk #(
  .PINS(PINS), .VERSION(VERSION), .WIN_OFS(WIN_OFS), .EOI_OFS(EOI_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .wr_fire(wr_fire), .st_same(st_same),
  .win_entry(win_entry), .stb_entry(stb_entry), .ent_wr_stb(ent_wr_stb),
  .eoi_stb(eoi_stb), .eoi_vector(eoi_vector)
);

// File: tb/irq_regwin_bench.sv
`timescale 1ns/1ps
module irq_regwin_bench;

  localparam int PINS  = 24;
  localparam int IDX_W = $clog2(PINS);
  localparam int NV    = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]       req_offset = 8'h00;
  logic [2:0]       req_size = 3'd4;
  logic [31:0]      req_wdata = 32'h0;
  logic             rsp_valid;
  logic [31:0]      rsp_rdata;
  logic             st_valid = 1'b0, st_remote_irr = 1'b0, st_deliv = 1'b0;
  logic [IDX_W-1:0] st_index = '0, eng_index = '0;
  logic [63:0]      eng_entry;
  logic             ent_wr_stb, eoi_stb;
  logic [IDX_W-1:0] ent_wr_index;
  logic [7:0]       eoi_vector;

  logic             b_rsp_valid, b_ent_wr_stb, b_eoi_stb;
  logic [31:0]      b_rsp_rdata;
  logic [63:0]      b_eng_entry;
  logic [IDX_W-1:0] b_ent_wr_index;
  logic [7:0]       b_eoi_vector;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_regwin #(.PINS(PINS)) u_irq_regwin (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .st_valid(st_valid), .st_index(st_index), .st_remote_irr(st_remote_irr),
    .st_deliv(st_deliv), .eng_index(eng_index), .eng_entry(eng_entry),
    .ent_wr_stb(ent_wr_stb), .ent_wr_index(ent_wr_index),
    .eoi_stb(eoi_stb), .eoi_vector(eoi_vector)
  );

  irq_regwin #(.PINS(PINS), .VERSION(8'h11)) u_irq_regwin_v11 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(b_rsp_valid), .rsp_rdata(b_rsp_rdata),
    .st_valid(st_valid), .st_index(st_index), .st_remote_irr(st_remote_irr),
    .st_deliv(st_deliv), .eng_index(eng_index), .eng_entry(b_eng_entry),
    .ent_wr_stb(b_ent_wr_stb), .ent_wr_index(b_ent_wr_index),
    .eoi_stb(b_eoi_stb), .eoi_vector(b_eoi_vector)
  );

  // {write, offset, size, wdata, expected read data}
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0},         // R1 select reset
    {1'b1, 8'h00, 3'd1, 32'h10,       32'h0},         // R2 byte write to select
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0001_0000}, // R1 entry 0 masked
    {1'b1, 8'h10, 3'd4, 32'h0000_8031,32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0000_8031}, // R6 low half
    {1'b1, 8'h00, 3'd2, 32'h11,       32'h0},
    {1'b1, 8'h10, 3'd4, 32'hAB00_0000,32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'hAB00_0000}, // R6 high half
    {1'b1, 8'h00, 3'd4, 32'h3F,       32'h0},
    {1'b1, 8'h10, 3'd4, 32'h1234_5678,32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h1234_5678}, // R6 last entry
    {1'b1, 8'h00, 3'd4, 32'h40,       32'h0},
    {1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF,32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0},         // R6 past the table
    {1'b1, 8'h00, 3'd4, 32'h05,       32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0},         // R6 gap index
    {1'b1, 8'h00, 3'd4, 32'h00,       32'h0},
    {1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF,32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0F00_0000}, // R4 ID field only
    {1'b1, 8'h00, 3'd4, 32'h02,       32'h0},
    {1'b1, 8'h10, 3'd4, 32'h0,        32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0F00_0000}, // R4 arb mirrors, R5 write ignored
    {1'b1, 8'h00, 3'd4, 32'h01,       32'h0},
    {1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF,32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0017_0020}, // R5 version word
    {1'b0, 8'h10, 3'd2, 32'h0,        32'h0},         // R3 short read
    {1'b1, 8'h00, 3'd4, 32'h12,       32'h0},
    {1'b1, 8'h10, 3'd1, 32'h55,       32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,        32'h0001_0000}, // R3 short write ignored
    {1'b0, 8'h00, 3'd1, 32'h0,        32'h0000_0012}, // R2 select readback
    {1'b1, 8'h00, 3'd4, 32'h1234,     32'h0},
    {1'b0, 8'h00, 3'd4, 32'h0,        32'h0000_0034}  // R2 low byte stored
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; returns with outputs of the following cycle sampled
  task automatic bus(input logic wr, input logic [7:0] ofs, input logic [2:0] sz,
                     input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic status(input int idx, input logic rirr, input logic dlv);
    st_valid = 1'b1; st_index = IDX_W'(idx); st_remote_irr = rirr; st_deliv = dlv;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    check("R1 ent_wr_stb", 64'(ent_wr_stb), 64'h0);
    check("R1 eoi_stb", 64'(eoi_stb), 64'h0);
    eng_index = IDX_W'(23); #0.1;
    check("R1/R12 entry 23 reset", eng_entry, 64'h0000_0000_0001_0000);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][75], VEC[i][74:67], VEC[i][66:64], VEC[i][63:32]);
      if (!VEC[i][75]) check($sformatf("R2-6 vector %0d", i), 64'(rsp_rdata), 64'(VEC[i][31:0]));
      else check($sformatf("R9 rsp vector %0d", i), 64'(rsp_valid), 64'h1);
    end

    // R11: status port sets protected bits of entry 2
    bus(1'b1, 8'h00, 3'd4, 32'h14);
    status(2, 1'b1, 1'b1);
    bus(1'b0, 8'h10, 3'd4, 32'h0);
    check("R11 status bits", 64'(rsp_rdata), 64'h0001_5000);

    // R7: level write keeps protected bits
    bus(1'b1, 8'h10, 3'd4, 32'h0000_8042);
    check("R9 entry strobe", 64'(ent_wr_stb), 64'h1);
    check("R9 entry index", 64'(ent_wr_index), 64'h2);
    bus(1'b0, 8'h10, 3'd4, 32'h0);
    check("R9 strobe is one cycle", 64'(ent_wr_stb), 64'h0);
    check("R7 level write", 64'(rsp_rdata), 64'h0000_D042);
    eng_index = IDX_W'(2); #0.1;
    check("R12 lookup", eng_entry, 64'h0000_0000_0000_D042);

    // R8: edge write clears remote-IRR, keeps delivery status
    bus(1'b1, 8'h10, 3'd4, 32'h0000_0042);
    bus(1'b0, 8'h10, 3'd4, 32'h0);
    check("R8 edge clears remote-IRR", 64'(rsp_rdata), 64'h0000_1042);

    // R7: data cannot set protected bits
    bus(1'b1, 8'h00, 3'd4, 32'h16);
    bus(1'b1, 8'h10, 3'd4, 32'h0000_D000);
    bus(1'b0, 8'h10, 3'd4, 32'h0);
    check("R7 data ignored on bits 12/14", 64'(rsp_rdata), 64'h0000_8000);

    // R8: level entry keeps remote-IRR across a high-half write
    status(3, 1'b1, 1'b0);
    bus(1'b1, 8'h00, 3'd4, 32'h17);
    bus(1'b1, 8'h10, 3'd4, 32'h1100_0000);
    bus(1'b1, 8'h00, 3'd4, 32'h16);
    bus(1'b0, 8'h10, 3'd4, 32'h0);
    check("R8 level keeps remote-IRR", 64'(rsp_rdata), 64'h0000_C000);

    // R9: non-entry window write gives no strobe
    bus(1'b1, 8'h00, 3'd4, 32'h00);
    bus(1'b1, 8'h10, 3'd4, 32'h0500_0000);
    check("R9 no strobe for ID write", 64'(ent_wr_stb), 64'h0);

    // R10: EOI register
    bus(1'b1, 8'h40, 3'd4, 32'h0000_01A7);
    check("R10 eoi strobe", 64'(eoi_stb), 64'h1);
    check("R10 eoi vector", 64'(eoi_vector), 64'hA7);
    check("R10 version 0x11 ignores eoi", 64'(b_eoi_stb), 64'h0);
    bus(1'b1, 8'h40, 3'd2, 32'h33);
    check("R10 short eoi ignored", 64'(eoi_stb), 64'h0);
    bus(1'b0, 8'h40, 3'd4, 32'h0);
    check("R10 eoi reads zero", 64'(rsp_rdata), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule